// File: doc/BRIEF.md
# Guarded Page Write Commit Controller

This block sits behind a serial byte engine in a small nonvolatile memory. It sees every byte of a transaction as a one-cycle strobe. The first byte is the command and the second is the byte address. Any further bytes are write data. The block collects the data for one 4-byte page into a buffer. It commits that buffer to the storage array only when three conditions hold: the write-enable latch was set, the write-protect input stayed high, and chip select rose on an exact legal clock count.

A committed write runs a self-timed cycle, and `busy_o` is high for the whole cycle. In the last cycle of the busy window the block drives one page-wide write on the array port, with a byte-enable mask. The array itself is outside the block. It is written only at completion, so reads issued while busy still return the old contents. The write-enable latch is set and cleared by request strobes from the command decoder. It also clears itself after every write cycle and whenever write-protect is low.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset `busy_o` and `mem_we_o` are low and the write-enable latch is clear, so a write frame without a preceding latch-set request causes no write.
- R2: A write frame (command byte 0x02, then the address byte, then data bytes) with the latch set and a legal count raises `busy_o` one cycle after `cs_rise_i`. `busy_o` stays high for exactly WRITE_CYCLES cycles. `mem_we_o` pulses once, in the last busy cycle, carrying the page (address bits 7:2), the byte-enable mask and the data.
- R3: A latch-clear request after a latch-set request leaves the latch clear, and the next write frame is ignored.
- R4: The latch clears when a write cycle completes, so a second write frame without a new latch-set request is ignored.
- R5: While `wp_i` is low, write frames and latch-set requests are ignored. Any low level on `wp_i` clears the latch.
- R6: If `wp_i` goes low after the data bytes but before `cs_rise_i`, the pending write is cancelled even when `wp_i` is high again at `cs_rise_i`.
- R7: Once the write cycle has started, `wp_i` going low does not stop it: the write still completes.
- R8: `cs_rise_i` with `bit_cnt_i` other than 24, 32, 40 or 48 abandons the write with no busy cycle and no array write, and the latch stays set.
- R9: Data byte k goes to lane (address[1:0]+k) mod 4 of the same page. Lane i is `mem_wdata_o[8i+7:8i]` and `mem_be_o[i]`. The address wraps within the page past lane 3.
- R10: Only lanes that received a byte have their `mem_be_o` bit set. A full page sets all four.
- R11: While busy, latch requests and new write frames are ignored. The frame in progress keeps its page and data, and no second cycle starts.
- R12: A frame whose command byte is not 0x02 never commits, and the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | One-cycle strobe for a received byte |
| byte_i | input | 8 | Received byte |
| cs_rise_i | input | 1 | One-cycle strobe when chip select rises |
| bit_cnt_i | input | CNT_W | Serial clock count at chip-select rise |
| wp_i | input | 1 | Write protect, low blocks writes |
| wel_set_i | input | 1 | Latch-set request |
| wel_clr_i | input | 1 | Latch-clear request |
| mem_we_o | output | 1 | Array page write strobe |
| mem_page_o | output | ADDR_W-2 | Array page index |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Page data, lane i in bits 8i+7:8i |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
The bench goes after the counts next to the legal ones (16, 28, 36, 56). A design that decodes the count loosely would commit on these counts and show an unexpected write. Starting offsets 3 and 0 exercise the lane wrap; a design that carries into the page index or ignores the offset would show a wrong mask or misplaced data. A write-protect glitch between the last data byte and chip-select rise must cancel the write. The same glitch during busy must not cancel it. Mixing these up either drops a committed write or lets a protected one through. Latch and frame traffic issued while busy must neither leave the latch set afterwards nor overwrite the page that is waiting to commit.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [1:0] {FS_OP, FS_ADDR, FS_DATA} frm_st_e;

  // legal = 8 bits each of command, address, and 1..page_bytes data bytes
  function automatic bit cnt_legal(input int unsigned c, input int unsigned page_bytes);
    return (c % 8 == 0) && (c / 8 >= 3) && (c / 8 <= 2 + page_bytes);
  endfunction
endpackage

// File: rtl/pcc_frame.sv
module pcc_frame #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 4,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    byte_vld_i,
  input  logic [7:0]              byte_i,
  input  logic                    cs_rise_i,
  input  logic                    arm_ok_i,
  input  logic                    hold_i,
  input  logic                    wp_i,
  output logic                    armed_o,
  output logic [PAGE_W-1:0]       page_o,
  output logic [PAGE_BYTES-1:0]   vld_o,
  output logic [8*PAGE_BYTES-1:0] data_o
);
  import pcc_pkg::*;

  frm_st_e           st_q;
  logic              armed_q;
  logic [OFF_W-1:0]  ptr_q;
  logic [PAGE_W-1:0] page_q;
  logic [PAGE_BYTES-1:0] vld_q;
  logic              data_stb;

  assign data_stb = byte_vld_i && (st_q == FS_DATA) && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= FS_OP;
      armed_q <= 1'b0;
      ptr_q   <= '0;
      page_q  <= '0;
      vld_q   <= '0;
    end else begin
      if (cs_rise_i) begin
        st_q    <= FS_OP;
        armed_q <= 1'b0;
      end else if (byte_vld_i) begin
        unique case (st_q)
          FS_OP: begin
            armed_q <= (byte_i == OP_WRITE) && arm_ok_i;
            st_q    <= FS_ADDR;
          end
          FS_ADDR: begin
            // page held while a committed write waits for its cycle
            if (!hold_i) begin
              page_q <= byte_i[ADDR_W-1:OFF_W];
              ptr_q  <= byte_i[OFF_W-1:0];
              vld_q  <= '0;
            end
            st_q <= FS_DATA;
          end
          default: begin
            if (armed_q) begin
              vld_q[ptr_q] <= 1'b1;
              ptr_q        <= ptr_q + OFF_W'(1);
            end
          end
        endcase
      end
      if (!wp_i) armed_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    lane_q <= '0;
      else if (data_stb && (ptr_q == OFF_W'(g)))      lane_q <= byte_i;
    end
    assign data_o[8*g +: 8] = lane_q;
  end

  assign armed_o = armed_q;
  assign page_o  = page_q;
  assign vld_o   = vld_q;
endmodule

// File: rtl/pcc_wel.sv
module pcc_wel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic wp_i,
  input  logic busy_i,
  input  logic done_i,
  output logic wel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wel_o <= 1'b0;
    else if (!wp_i || done_i)   wel_o <= 1'b0;
    else if (busy_i)            wel_o <= wel_o;
    else if (clr_i)             wel_o <= 1'b0;
    else if (set_i)             wel_o <= 1'b1;
  end
endmodule

// File: rtl/pcc_cycle.sv
module pcc_cycle #(
  parameter int WRITE_CYCLES = 1_000_000,
  localparam int CYC_W       = $clog2(WRITE_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CYC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - CYC_W'(1);
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CYC_W'(WRITE_CYCLES - 1);
    end
  end

  assign done_o = busy_o && (cnt_q == '0);
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int ADDR_W       = 8,
  parameter int PAGE_BYTES   = 4,
  parameter int CNT_W        = 8,
  parameter int WRITE_CYCLES = 1_000_000,
  localparam int OFF_W       = $clog2(PAGE_BYTES),
  localparam int PAGE_W      = ADDR_W - OFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    byte_vld_i,
  input  logic [7:0]              byte_i,
  input  logic                    cs_rise_i,
  input  logic [CNT_W-1:0]        bit_cnt_i,
  input  logic                    wp_i,
  input  logic                    wel_set_i,
  input  logic                    wel_clr_i,
  output logic                    mem_we_o,
  output logic [PAGE_W-1:0]       mem_page_o,
  output logic [PAGE_BYTES-1:0]   mem_be_o,
  output logic [8*PAGE_BYTES-1:0] mem_wdata_o,
  output logic                    busy_o
);
  logic wel, armed, busy, done, cnt_ok, start;
  logic [PAGE_BYTES-1:0] vld;

  assign cnt_ok = pcc_pkg::cnt_legal(int'(bit_cnt_i), PAGE_BYTES);
  assign start  = cs_rise_i && armed && cnt_ok && wp_i && (|vld) && !busy;

  pcc_frame #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_frame (
    .clk_i, .rst_ni, .byte_vld_i, .byte_i, .cs_rise_i,
    .arm_ok_i (wel && !busy && wp_i),
    .hold_i   (busy),
    .wp_i,
    .armed_o  (armed),
    .page_o   (mem_page_o),
    .vld_o    (vld),
    .data_o   (mem_wdata_o)
  );

  pcc_wel u_wel (
    .clk_i, .rst_ni,
    .set_i  (wel_set_i),
    .clr_i  (wel_clr_i),
    .wp_i,
    .busy_i (busy),
    .done_i (done),
    .wel_o  (wel)
  );

  pcc_cycle #(.WRITE_CYCLES(WRITE_CYCLES)) u_cycle (
    .clk_i, .rst_ni,
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done)
  );

  assign mem_we_o = done;
  assign mem_be_o = vld;
  assign busy_o   = busy;
endmodule

// File: rtl/pcc_chk.sv
module pcc_chk #(
  parameter int CNT_W      = 8,
  parameter int PAGE_BYTES = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cs_rise_i,
  input logic [CNT_W-1:0]      bit_cnt_i,
  input logic                  wp_i,
  input logic                  mem_we_o,
  input logic [PAGE_BYTES-1:0] mem_be_o,
  input logic                  busy_o
);
  // R2
  busy_from_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise_i));
  // R8
  legal_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> pcc_pkg::cnt_legal(int'($past(bit_cnt_i)), PAGE_BYTES));
  // R5
  wp_high_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wp_i));
  // R2
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  // R2
  we_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !busy_o);
  // R7
  busy_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_we_o) |=> busy_o);
  // R10
  be_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_be_o != '0));
endmodule

bind page_commit_ctrl pcc_chk #(.CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) u_pcc_chk (
  .clk_i, .rst_ni, .cs_rise_i, .bit_cnt_i, .wp_i, .mem_we_o, .mem_be_o, .busy_o
);

// File: tb/page_commit_ctrl_tb_top.sv
`timescale 1ns/1ps
module page_commit_ctrl_tb_top;
  localparam int WC = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, byte_vld, cs_rise, wp, wel_set, wel_clr;
  logic [7:0] byte_d, bit_cnt;
  logic mem_we, busy;
  logic [5:0] mem_page;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;

  page_commit_ctrl #(.WRITE_CYCLES(WC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(byte_vld), .byte_i(byte_d),
    .cs_rise_i(cs_rise), .bit_cnt_i(bit_cnt), .wp_i(wp),
    .wel_set_i(wel_set), .wel_clr_i(wel_clr),
    .mem_we_o(mem_we), .mem_page_o(mem_page), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .busy_o(busy)
  );

  typedef struct {logic [5:0] page; logic [3:0] be; logic [31:0] data;} exp_t;
  exp_t expq[$];
  int n_chk = 0, n_fail = 0, n_wr = 0, busy_run = 0;
  bit busy_seen = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compare array writes against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin busy_seen = 1; busy_run++; end
      if (mem_we) begin
        n_wr++;
        chk(busy_run == WC, "R2", "busy length", busy_run, WC);
        if (expq.size() == 0) chk(0, "R2", "unexpected write", {26'd0, mem_page}, 0);
        else begin
          exp_t e;
          logic [31:0] m;
          e = expq.pop_front();
          for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{mem_be[i]}};
          chk(mem_page == e.page, "R2", "page", {26'd0, mem_page}, {26'd0, e.page});
          chk(mem_be == e.be, "R10", "byte enables", {28'd0, mem_be}, {28'd0, e.be});
          chk((mem_wdata & m) == e.data, "R9", "lane data", mem_wdata & m, e.data);
        end
      end
      if (!busy) busy_run = 0;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic send_byte(input logic [7:0] b);
    tick(); byte_vld = 1; byte_d = b;
    tick(); byte_vld = 0;
  endtask

  task automatic req_set(); tick(); wel_set = 1; tick(); wel_set = 0; endtask
  task automatic req_clr(); tick(); wel_clr = 1; tick(); wel_clr = 0; endtask

  task automatic frame(input logic [7:0] op, input logic [7:0] addr, input int n,
                       input logic [31:0] dw, input int bits, input bit wp_glitch);
    send_byte(op);
    send_byte(addr);
    for (int k = 0; k < n; k++) send_byte(dw[8*k +: 8]);
    if (wp_glitch) begin tick(); wp = 0; tick(); wp = 1; end
    tick(); cs_rise = 1; bit_cnt = 8'(bits);
    tick(); cs_rise = 0;
  endtask

  task automatic push_exp(input logic [7:0] addr, input int n, input logic [31:0] dw);
    exp_t e;
    e.page = addr[7:2]; e.be = '0; e.data = '0;
    for (int k = 0; k < n; k++) begin
      int lane;
      lane = (int'(addr[1:0]) + k) % 4;
      e.be[lane] = 1'b1;
      e.data[8*lane +: 8] = dw[8*k +: 8];
    end
    expq.push_back(e);
  endtask

  task automatic good_write(input logic [7:0] addr, input int n, input logic [31:0] dw,
                            input string req);
    push_exp(addr, n, dw);
    frame(8'h02, addr, n, dw, 8 * (n + 2), 0);
    for (int t = 0; t < WC + 10 && expq.size() != 0; t++) tick();
    tick();
    chk(expq.size() == 0 && !busy, req, "write completed", expq.size(), 0);
  endtask

  task automatic ignored_frame(input logic [7:0] op, input logic [7:0] addr, input int n,
                               input int bits, input bit wp_glitch, input string req);
    int n0;
    n0 = n_wr; busy_seen = 0;
    frame(op, addr, n, 32'hC3C2C1C0, bits, wp_glitch);
    repeat (WC + 4) tick();
    chk(!busy_seen && n_wr == n0, req, "frame ignored", {31'd0, busy_seen}, 0);
  endtask

  initial begin
    rst_n = 0; byte_vld = 0; byte_d = 0; cs_rise = 0; bit_cnt = 0;
    wp = 1; wel_set = 0; wel_clr = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(!busy && !mem_we, "R1", "idle after reset", {30'd0, busy, mem_we}, 0);
    ignored_frame(8'h02, 8'h10, 1, 24, 0, "R1");

    req_set(); good_write(8'h10, 1, 32'h000000A5, "R2");
    ignored_frame(8'h02, 8'h14, 1, 24, 0, "R4");

    req_set(); good_write(8'h23, 3, 32'h00332211, "R9");
    req_set(); good_write(8'h40, 4, 32'h44332211, "R10");

    req_set();
    ignored_frame(8'h02, 8'h50, 1, 28, 0, "R8");
    ignored_frame(8'h02, 8'h50, 2, 36, 0, "R8");
    ignored_frame(8'h02, 8'h50, 1, 16, 0, "R8");
    ignored_frame(8'h02, 8'h50, 4, 56, 0, "R8");
    good_write(8'h54, 2, 32'h0000BEEF, "R8");

    req_set(); req_clr();
    ignored_frame(8'h02, 8'h60, 1, 24, 0, "R3");

    tick(); wp = 0;
    req_set();
    ignored_frame(8'h02, 8'h64, 1, 24, 0, "R5");
    tick(); wp = 1;
    ignored_frame(8'h02, 8'h64, 1, 24, 0, "R5");
    req_set(); tick(); wp = 0; tick(); wp = 1;
    ignored_frame(8'h02, 8'h68, 1, 24, 0, "R5");

    req_set();
    ignored_frame(8'h02, 8'h70, 2, 32, 1, "R6");

    req_set();
    push_exp(8'h80, 2, 32'h00005A6B);
    frame(8'h02, 8'h80, 2, 32'h00005A6B, 32, 0);
    repeat (3) tick(); wp = 0; repeat (3) tick(); wp = 1;
    for (int t = 0; t < WC + 10 && expq.size() != 0; t++) tick();
    chk(expq.size() == 0, "R7", "write survives wp drop", expq.size(), 0);

    req_set();
    push_exp(8'h91, 1, 32'h00000077);
    frame(8'h02, 8'h91, 1, 32'h00000077, 24, 0);
    req_set();
    frame(8'h02, 8'hA2, 1, 32'h00000099, 24, 0);
    for (int t = 0; t < WC + 10 && expq.size() != 0; t++) tick();
    tick();
    chk(expq.size() == 0 && !busy, "R11", "first write only", expq.size(), 0);
    ignored_frame(8'h02, 8'hA4, 1, 24, 0, "R11");

    req_set();
    ignored_frame(8'h03, 8'hB0, 1, 24, 0, "R12");
    good_write(8'hB0, 1, 32'h0000001E, "R12");

    repeat (4) tick();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule